// File: doc/BRIEF.md
# Serial Chain Upset Tester

This block checks a long chain of serial-in serial-out flip-flops for single-event upsets. A free-running 32-bit word generator feeds a rotating shifter. The shifter sends each word into the chain one bit per clock, most significant bit first. At the far end the bits are put back together into 32-bit words. Each rebuilt word is compared with the word that came before it plus one. When the two differ, an upset counter advances. A second counter advances for every rebuilt word, so a host can divide the two counts to get an upset rate.

The whole path moves only while `run_i` is high. The generator, the shifter, every chain stage and the receiver all hold their state together when it is low. Word alignment therefore survives any pause. `start_i` clears both counters and the priming state at any time. The rebuilt words leave on a valid-only stream (`rx_valid_o`, `rx_word_o`). That stream has no ready signal, because a chain under test cannot be stalled. A consumer must take each beat in the cycle it is offered. `upset_i` models a particle hit: it inverts the bit entering the chain in that cycle.

Top module: `seu_chain_tester`

## Requirements
- R1: While `rst_n` is low and after reset, `rx_valid_o` is 0, `primed_o` is 0, and both counters read 0. The generator restarts at word value 0.
- R2: When `run_i` is held high from the first clock after reset, the first `rx_valid_o` pulse follows the (33 + CHAIN_LEN)-th rising edge.
- R3: Words are sent MSB first through CHAIN_LEN stages. On an undisturbed chain, the first received word after reset is 0, and each later received word is the previous one plus one.
- R4: The first word received after reset or `start_i` is never compared. It only loads the prediction (word + 1), sets `primed_o`, and leaves `err_cnt_o` unchanged.
- R5: Each compared word that differs from the prediction adds one to `err_cnt_o`. The prediction is always reloaded from the received word plus one. A single flipped bit in a compared word therefore costs exactly two errors.
- R6: `word_cnt_o` adds one for every received word, including the priming word, and changes at no other time.
- R7: `start_i` clears both counters and `primed_o` on the next edge. If `start_i` falls in the same cycle as a word strobe, the word is dropped: it is neither counted nor used for priming.
- R8: While `run_i` is low, no bit moves and no strobe appears. After a pause in the middle of a word, the stream resumes with no errors.
- R9: `upset_i` has no effect while `run_i` is low.
- R10: Both counters saturate at all ones (2^CNT_W - 1) and never wrap.
- R11: `rx_valid_o` is a single-cycle pulse. Two pulses are at least 32 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Clear counters and priming state |
| run_i | input | 1 | Advance the whole generator/chain/receiver path |
| upset_i | input | 1 | Invert the bit entering the chain this cycle |
| rx_valid_o | output | 1 | Received-word strobe (no back-pressure) |
| rx_word_o | output | 32 | Received word, valid with `rx_valid_o` |
| primed_o | output | 1 | Prediction register holds a value |
| err_cnt_o | output | CNT_W | Saturating upset-event count |
| word_cnt_o | output | CNT_W | Saturating received-word count |

## Verification
Two events can land on the same edge: a clear from `start_i` and a completed word reaching the checker. The bench provokes this by watching for `rx_valid_o` between edges and raising `start_i` in that same cycle. It then judges the result: after the edge, both counters and `primed_o` must read zero. The next word must act as a priming word, so the word count reaches 1 while the error count stays at 0. A second overlap, where an increment meets a saturated counter, is forced by running the counters past their ceiling with a narrow counter width.

// File: rtl/seu_tester_pkg.sv
package seu_tester_pkg;
  localparam int unsigned TW = 32;
  typedef logic [TW-1:0] word_t;

  function automatic word_t rotl1(word_t w);
    return {w[TW-2:0], w[TW-1]};
  endfunction
endpackage

// File: rtl/seu_word_serializer.sv
module seu_word_serializer
  import seu_tester_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  output logic bit_o
);
  localparam int unsigned PW = $clog2(TW);

  logic [PW-1:0] pos_q;
  word_t         gen_q;
  word_t         rot_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q <= '0;
      gen_q <= '0;
      rot_q <= '0;
    end else if (adv_i) begin
      if (pos_q == '0) begin
        rot_q <= gen_q;
        gen_q <= gen_q + 1'b1;
      end else begin
        rot_q <= rotl1(rot_q);
      end
      pos_q <= pos_q + 1'b1;
    end
  end

  assign bit_o = rot_q[TW-1];

  // R8: generator frozen while the path is gated
  p_gen_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(gen_q));
endmodule

// File: rtl/seu_shift_chain.sv
module seu_shift_chain #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic adv_i,
  input  logic din_i,
  output logic dout_o
);
  logic [LEN-1:0] st_q;

  generate
    if (LEN == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rst_n)     st_q <= '0;
        else if (adv_i) st_q <= din_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rst_n)     st_q <= '0;
        else if (adv_i) st_q <= {st_q[LEN-2:0], din_i};
      end
    end
  endgenerate

  assign dout_o = st_q[LEN-1];

  // R9: chain contents hold whenever the path is gated
  p_chain_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !adv_i |=> $stable(st_q));
endmodule

// File: rtl/seu_word_deserializer.sv
module seu_word_deserializer
  import seu_tester_pkg::*;
#(
  parameter int unsigned LEN = 16
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  adv_i,
  input  logic  din_i,
  output logic  valid_o,
  output word_t word_o
);
  localparam int unsigned LW = $clog2(LEN + 1);
  localparam int unsigned PW = $clog2(TW);

  logic [LW-1:0] lat_q;
  logic          go_q;
  logic [PW-1:0] pos_q;
  word_t         sh_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_q   <= '0;
      go_q    <= 1'b0;
      pos_q   <= '0;
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (adv_i) begin
        if (!go_q) begin
          if (lat_q == LW'(LEN)) go_q <= 1'b1;
          else                   lat_q <= lat_q + 1'b1;
        end else begin
          sh_q  <= {sh_q[TW-2:0], din_i};
          pos_q <= pos_q + 1'b1;
          if (pos_q == PW'(TW - 1)) begin
            word_o  <= {sh_q[TW-2:0], din_i};
            valid_o <= 1'b1;
          end
        end
      end
    end
  end

  // R11: strobe lasts one cycle
  p_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);
  // R8: a strobe only follows an advancing cycle
  p_strobe_adv_r8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $past(adv_i));
endmodule

// File: rtl/seu_upset_checker.sv
module seu_upset_checker
  import seu_tester_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             valid_i,
  input  word_t            word_i,
  output logic             primed_o,
  output logic [CNT_W-1:0] err_o,
  output logic [CNT_W-1:0] tot_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  word_t exp_q;

  always_ff @(posedge clk) begin
    if (!rst_n || start_i) begin
      primed_o <= 1'b0;
      err_o    <= '0;
      tot_o    <= '0;
      exp_q    <= '0;
    end else if (valid_i) begin
      if (tot_o != CMAX) tot_o <= tot_o + 1'b1;
      if (primed_o && (word_i != exp_q) && (err_o != CMAX)) err_o <= err_o + 1'b1;
      exp_q    <= word_i + 1'b1;
      primed_o <= 1'b1;
    end
  end

  // R7: clear wins over everything
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (err_o == '0) && (tot_o == '0) && !primed_o);
  // R6: word count moves only on a strobe
  p_tot_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_i && !start_i) |=> $stable(tot_o));
  // R4: priming word never adds an error
  p_prime_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && !primed_o && !start_i) |=> $stable(err_o));
  // R10: saturated counters hold
  p_err_sat_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o == CMAX && !start_i) |=> err_o == CMAX);
  // R5: errors never outnumber words
  p_err_le_tot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o <= tot_o);
endmodule

// File: rtl/seu_chain_tester.sv
module seu_chain_tester
  import seu_tester_pkg::*;
#(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned CNT_W     = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic             upset_i,
  output logic             rx_valid_o,
  output logic [TW-1:0]    rx_word_o,
  output logic             primed_o,
  output logic [CNT_W-1:0] err_cnt_o,
  output logic [CNT_W-1:0] word_cnt_o
);
  logic  ser_bit;
  logic  chain_in;
  logic  chain_out;
  word_t rx_word;

  seu_word_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .adv_i(run_i), .bit_o(ser_bit)
  );

  assign chain_in = ser_bit ^ upset_i;

  seu_shift_chain #(.LEN(CHAIN_LEN)) u_chain (
    .clk(clk), .rst_n(rst_n), .adv_i(run_i), .din_i(chain_in), .dout_o(chain_out)
  );

  seu_word_deserializer #(.LEN(CHAIN_LEN)) u_des (
    .clk(clk), .rst_n(rst_n), .adv_i(run_i), .din_i(chain_out),
    .valid_o(rx_valid_o), .word_o(rx_word)
  );

  assign rx_word_o = rx_word;

  seu_upset_checker #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .valid_i(rx_valid_o),
    .word_i(rx_word), .primed_o(primed_o), .err_o(err_cnt_o), .tot_o(word_cnt_o)
  );
endmodule

// File: tb/seu_chain_tester_tb.sv
module seu_chain_tester_tb;
  localparam int unsigned L  = 5;
  localparam int unsigned CW = 4;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rst_n = 1'b0, start_i = 1'b0, run_i = 1'b0, upset_i = 1'b0;
  logic rx_valid_o, primed_o;
  logic [31:0] rx_word_o;
  logic [CW-1:0] err_cnt_o, word_cnt_o;
  int nchk = 0, nerr = 0;

  always #5 clk = ~clk;

  seu_chain_tester #(.CHAIN_LEN(L), .CNT_W(CW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .run_i(run_i), .upset_i(upset_i),
    .rx_valid_o(rx_valid_o), .rx_word_o(rx_word_o), .primed_o(primed_o),
    .err_cnt_o(err_cnt_o), .word_cnt_o(word_cnt_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // waits for n strobes, then one more cycle for the counters
  task automatic wait_words(int n);
    for (int i = 0; i < n; i++) begin
      do @(negedge clk); while (!rx_valid_o);
    end
    @(negedge clk);
  endtask

  task automatic do_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 valid", rx_valid_o, 0);
    chk("R1 primed", primed_o, 0);
    chk("R1 err", err_cnt_o, 0);
    chk("R1 words", word_cnt_o, 0);
  endtask

  // run from reset; flip MSB of word 0, which is the priming word
  task automatic t_first_word();
    int k;
    rst_n = 1'b1; run_i = 1'b1;
    @(posedge clk); k = 1;
    @(negedge clk) upset_i = 1'b1;
    @(posedge clk); k = 2;
    @(negedge clk) upset_i = 1'b0;
    while (!rx_valid_o && k < 1000) begin
      @(posedge clk); k++;
      @(negedge clk);
    end
    chk("R2 first strobe edge", k, 33 + L);
    chk("R3 MSB first", rx_word_o, 32'h8000_0000);
    @(negedge clk);
    chk("R4 primed", primed_o, 1);
    chk("R4 no error on priming", err_cnt_o, 0);
    chk("R6 priming counted", word_cnt_o, 1);
    wait_words(1);
    chk("R3 next word", rx_word_o, 32'h1);
    chk("R5 one error after bad prime", err_cnt_o, 1);
  endtask

  task automatic t_clean();
    logic [31:0] prev;
    do_start();
    wait_words(1);
    prev = rx_word_o;
    for (int i = 0; i < 4; i++) begin
      wait_words(1);
      chk("R3 increment", rx_word_o, prev + 1);
      prev = rx_word_o;
    end
    chk("R5 clean run", err_cnt_o, 0);
    chk("R6 word count", word_cnt_o, 5);
  endtask

  task automatic t_single_upset();
    do_start();
    wait_words(2);
    @(negedge clk) upset_i = 1'b1;
    @(negedge clk) upset_i = 1'b0;
    wait_words(4);
    chk("R5 two errors per flip", err_cnt_o, 2);
    chk("R6 words", word_cnt_o, 6);
  endtask

  task automatic t_pause();
    logic [CW-1:0] w0;
    logic seen;
    do_start();
    wait_words(2);
    repeat (11) @(negedge clk);
    run_i = 1'b0;
    w0 = word_cnt_o;
    seen = 1'b0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      upset_i = (i == 20);
      if (rx_valid_o) seen = 1'b1;
    end
    upset_i = 1'b0;
    chk("R8 no strobe while stopped", seen, 0);
    chk("R8 count held", word_cnt_o, w0);
    run_i = 1'b1;
    wait_words(3);
    chk("R9 upset ignored when stopped", err_cnt_o, 0);
    chk("R8 resumes", word_cnt_o, w0 + 3);
  endtask

  task automatic t_start_collide();
    do @(negedge clk); while (!rx_valid_o);
    start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R7 words cleared", word_cnt_o, 0);
    chk("R7 errors cleared", err_cnt_o, 0);
    chk("R7 priming cleared", primed_o, 0);
    wait_words(1);
    chk("R7 next word primes", word_cnt_o, 1);
    chk("R7 no error", err_cnt_o, 0);
  endtask

  task automatic t_saturate();
    int gaps;
    do_start();
    wait_words(2);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk) upset_i = 1'b1;
      @(negedge clk) upset_i = 1'b0;
      wait_words(2);
    end
    wait_words(3);
    chk("R10 error saturates", err_cnt_o, CMAX);
    chk("R10 words saturate", word_cnt_o, CMAX);
    gaps = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (rx_valid_o) gaps++;
    end
    chk("R11 at most one strobe per 32 cycles", (gaps <= 2) ? 1 : 0, 1);
    chk("R10 still saturated", word_cnt_o, CMAX);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    t_reset();
    t_first_word();
    t_clean();
    t_single_upset();
    t_pause();
    t_start_collide();
    t_saturate();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule